// File: doc/BRIEF.md
# Burst Read Address Generator

This block turns a compact read request into a stream of word addresses for a memory arbiter. A request holds only a start address and a word count. It arrives over a valid/ready handshake from a small queue upstream that crosses the request in from the display clock domain. Inside, the block keeps just a running address and a remaining count, so no deep queue of individual addresses is needed. The block runs entirely in the memory clock domain.

Toward the arbiter the block acts as a read-request agent that looks like a request FIFO which is non-empty while words remain. A pending flag is high while any word of the current burst is still owed. The current word address is always visible. Each grant consumes one address, moves the address up by one word and lowers the count. Read data returns to the requester's own return queue elsewhere; that path is not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the remaining count and the address. The cycle after reset releases, `arb_pend` is 0 and `req_ready` is 1.
- R2: A request accepted with a nonzero length (`req_valid` and `req_ready` high at a clock edge) makes `arb_pend` high from the next cycle, with `arb_addr` equal to the accepted start address.
- R3: Each clock edge with `arb_pend` and `arb_grant` both high advances `arb_addr` by exactly one word.
- R4: A request of length N produces exactly N granted addresses, start through start+N-1, in increasing order. `arb_pend` falls in the cycle after the N-th grant.
- R5: `req_ready` is high exactly when no word of the current burst remains, which is when `arb_pend` is low.
- R6: A request of length 0 is accepted and dropped. `arb_pend` stays low, `req_ready` stays high and `arb_addr` is unchanged.
- R7: A grant while `arb_pend` is low has no effect on `arb_addr` or `arb_pend`.
- R8: The address wraps modulo 2^AW, so the word after the all-ones address is address 0.
- R9: While `arb_pend` is high and `arb_grant` is low, `arb_addr` holds its value.
- R10: A request offered while a burst is still in progress is not taken until the burst completes. It is then served in full after the earlier burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream offers a request |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | AW | Start word address of the request |
| req_len | input | CW | Number of words to read |
| arb_pend | output | 1 | Words of the current burst remain |
| arb_grant | input | 1 | Arbiter consumes the current address |
| arb_addr | output | AW | Current word address offered to the arbiter |

## Verification
The assertions assume that upstream holds `req_addr` and `req_len` steady while `req_valid` waits for `req_ready`. They also assume that the arbiter may raise `arb_grant` in any cycle, including idle ones. The driver changes request fields only on falling edges and keeps them fixed until the handshake completes. The grant driver deliberately raises grants while nothing is pending and during zero-length drops, so the idle-grant and hold properties are exercised. Grant patterns alternate between continuous, every other cycle and every third cycle, so stalls occur in the middle of bursts and across the address wrap.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // What the generator does at the next clock edge.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,  // hold everything
    EV_LOAD = 2'd1,  // take a new burst with nonzero length
    EV_DROP = 2'd2,  // take a zero-length request, change nothing
    EV_STEP = 2'd3   // arbiter consumed one address
  } bag_evt_e;

endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          req_valid,
  input  logic [CW-1:0] req_len,
  input  logic          arb_grant,
  input  logic          cnt_zero,
  output logic          req_ready,
  output bag_evt_e      evt
);

  // Decode the single event for this cycle. Idle: only requests matter.
  // Busy: only grants matter.
  function automatic bag_evt_e decode_evt(
    input logic          idle,
    input logic          valid,
    input logic [CW-1:0] len,
    input logic          grant
  );
    bag_evt_e e;
    e = EV_NONE;
    if (idle) begin
      if (valid) e = (len == '0) ? EV_DROP : EV_LOAD;
    end else if (grant) begin
      e = EV_STEP;
    end
    return e;
  endfunction

  assign req_ready = cnt_zero;
  assign evt       = decode_evt(cnt_zero, req_valid, req_len, arb_grant);

endmodule

// File: rtl/bag_len_ctr.sv
module bag_len_ctr
  import bag_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  bag_evt_e      evt,
  input  logic [CW-1:0] load_len,
  output logic          cnt_zero,
  output logic          last_beat
);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] len_next(
    input logic [CW-1:0] cur,
    input bag_evt_e      e,
    input logic [CW-1:0] ld
  );
    logic [CW-1:0] n;
    case (e)
      EV_LOAD: n = ld;
      EV_STEP: n = cur - 1'b1;
      default: n = cur;
    endcase
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= len_next(cnt_q, evt, load_len);
  end

  assign cnt_zero  = (cnt_q == '0);
  assign last_beat = (cnt_q == {{(CW-1){1'b0}}, 1'b1});

  // R4: the grant on the final word empties the burst
  a_r4_last_empties: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_STEP && last_beat) |=> cnt_zero);

  // R4: a grant on a longer burst leaves words outstanding
  a_r4_more_left: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_STEP && !last_beat) |=> !cnt_zero);

endmodule

// File: rtl/bag_addr_ctr.sv
module bag_addr_ctr
  import bag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  bag_evt_e      evt,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q;

  // Word increment, wrapping naturally modulo 2^AW.
  function automatic logic [AW-1:0] addr_next(
    input logic [AW-1:0] cur,
    input bag_evt_e      e,
    input logic [AW-1:0] ld
  );
    logic [AW-1:0] n;
    case (e)
      EV_LOAD: n = ld;
      EV_STEP: n = cur + 1'b1;
      default: n = cur;
    endcase
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_next(addr_q, evt, load_addr);
  end

  assign addr = addr_q;

  // R3: one word per consumed address
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_STEP) |=> (addr == $past(addr) + 1'b1));

  // R8: all-ones rolls over to zero
  a_r8_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_STEP && (&addr)) |=> (addr == '0));

  // R9/R6: no step and no load means the address stays put
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_NONE || evt == EV_DROP) |=> $stable(addr));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_len,
  output logic          arb_pend,
  input  logic          arb_grant,
  output logic [AW-1:0] arb_addr
);

  bag_evt_e evt;
  logic     cnt_zero;
  logic     last_beat;

  // Named events for the assertions below.
  logic take_burst;
  logic take_empty;
  assign take_burst = (evt == EV_LOAD);
  assign take_empty = (evt == EV_DROP);

  bag_ctrl #(.CW(CW)) u_ctrl (
    .req_valid (req_valid),
    .req_len   (req_len),
    .arb_grant (arb_grant),
    .cnt_zero  (cnt_zero),
    .req_ready (req_ready),
    .evt       (evt)
  );

  bag_len_ctr #(.CW(CW)) u_len (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .load_len  (req_len),
    .cnt_zero  (cnt_zero),
    .last_beat (last_beat)
  );

  bag_addr_ctr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .load_addr (req_addr),
    .addr      (arb_addr)
  );

  assign arb_pend = !cnt_zero;

  // R2: a nonzero request shows up as pending at its start address
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len != '0) |=>
      (arb_pend && arb_addr == $past(req_addr)));

  // R6: a zero-length request leaves the agent idle
  a_r6_zero_len: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> (!arb_pend && req_ready));

  // R7: grants with nothing pending and no request change nothing
  a_r7_idle_grant: assert property (@(posedge clk) disable iff (rst)
    (!arb_pend && !req_valid) |=> (!arb_pend && $stable(arb_addr)));

  // R10: no handshake while a burst is outstanding
  a_r10_busy_block: assert property (@(posedge clk) disable iff (rst)
    (arb_pend && !(arb_grant && last_beat)) |=> !req_ready);

  // R5: ready and pending are complementary at the ports
  a_r5_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready != arb_pend);

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_len = '0;
  logic          arb_pend;
  logic          arb_grant = 1'b0;
  logic [AW-1:0] arb_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int gmode    = 0;   // 0 always, 1 every other, 2 every third, 3 never
  bit run_mon  = 1'b0;
  bit done     = 1'b0;
  logic [AW-1:0] exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  burst_addr_gen #(.AW(AW), .CW(CW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .arb_pend  (arb_pend),
    .arb_grant (arb_grant),
    .arb_addr  (arb_addr)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: offer a request, push its expected addresses when taken.
  task automatic send_req(input logic [AW-1:0] a, input logic [CW-1:0] n);
    @(negedge clk);
    req_addr  = a;
    req_len   = n;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < int'(n); i++) exp_q.push_back(a + AW'(i));
    @(negedge clk);
    req_valid = 1'b0;
    if (n != 0) begin
      chk(arb_pend == 1'b1, "R2 pending after load", 64'(arb_pend), 64'd1);
      chk(arb_addr == a, "R2 start address", 64'(arb_addr), 64'(a));
    end
  endtask

  task automatic wait_idle();
    while (arb_pend || exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor and grant driver: scoreboard compare per consumed address.
  initial begin
    int cyc = 0;
    logic [AW-1:0] prev_addr = '0;
    bit prev_hold = 1'b0;
    forever begin
      @(negedge clk);
      if (run_mon) begin
        if (prev_hold)
          chk(arb_addr == prev_addr, "R9 hold without grant",
              64'(arb_addr), 64'(prev_addr));
        chk(req_ready == !arb_pend, "R5 ready vs pending",
            64'(req_ready), 64'(!arb_pend));
        case (gmode)
          0: arb_grant = 1'b1;
          1: arb_grant = cyc[0];
          2: arb_grant = (cyc % 3 == 0);
          default: arb_grant = 1'b0;
        endcase
        cyc++;
        if (arb_pend && arb_grant) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4 extra address", 64'(arb_addr), 64'd0);
          end else begin
            logic [AW-1:0] e;
            e = exp_q.pop_front();
            chk(arb_addr == e, "R3/R4/R8 granted address",
                64'(arb_addr), 64'(e));
          end
        end
        prev_hold = arb_pend && !arb_grant;
        prev_addr = arb_addr;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(arb_pend == 1'b0, "R1 pending after reset", 64'(arb_pend), 64'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(arb_addr == '0, "R1 address after reset", 64'(arb_addr), 64'd0);
    run_mon = 1'b1;

    // Continuous grants
    gmode = 0;
    send_req(32'h0000_1000, 16'd5);
    wait_idle();

    // Alternating grants; second request waits behind the first (R10)
    gmode = 1;
    send_req(32'h0000_2000, 16'd3);
    send_req(32'h0000_3000, 16'd4);
    wait_idle();
    chk(arb_addr == 32'h0000_3004, "R10 both bursts served",
        64'(arb_addr), 64'h3004);

    // Zero-length request while grants are offered (R6)
    gmode = 0;
    send_req(32'h0000_4000, 16'd0);
    chk(arb_pend == 1'b0, "R6 zero length stays idle", 64'(arb_pend), 64'd0);
    chk(req_ready == 1'b1, "R6 ready after drop", 64'(req_ready), 64'd1);
    chk(arb_addr == 32'h0000_3004, "R6 address unchanged",
        64'(arb_addr), 64'h3004);

    // Idle grants (R7)
    repeat (5) @(negedge clk);
    chk(arb_pend == 1'b0, "R7 idle grant pending", 64'(arb_pend), 64'd0);
    chk(arb_addr == 32'h0000_3004, "R7 idle grant address",
        64'(arb_addr), 64'h3004);

    // Sparse grants across the wrap (R8, R9)
    gmode = 2;
    send_req(32'hFFFF_FFFE, 16'd4);
    wait_idle();
    @(negedge clk);
    chk(arb_addr == 32'h0000_0002, "R8 address after wrap",
        64'(arb_addr), 64'h2);

    // Single word burst (R4)
    gmode = 1;
    send_req(32'h0000_5555, 16'd1);
    wait_idle();
    @(negedge clk);
    chk(arb_pend == 1'b0, "R4 single burst done", 64'(arb_pend), 64'd0);
    chk(exp_q.size() == 0, "R4 all addresses granted",
        64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule